// File: doc/BRIEF.md
# Bob Line-Doubling Deinterlacer

This block turns a packetised stream of interlaced fields into progressive frames without storing a field. A control packet sets the field width and height. The video packet after it is rebuilt line by line. Each incoming row goes straight to the output and is written into a one-row buffer at the same time. The row is then played out a second time from the buffer while the input is held off. Output frames have the field's width and twice its height. Each control packet is passed downstream with its height doubled, so it describes the frame that follows it.

The end of each video packet is judged against the most recent control packet:

- **Late end-of-packet:** pixels beyond the expected field size are swallowed without output.
- **Early end-of-packet:** the output line in progress is completed with zero pixels, that line is repeated, and the frame closes with end-of-packet.

An optional discard mode drops whole fields of one parity. The dropped fields are consumed at full input rate and produce no output.

Stream beats carry a start marker, an end marker and a data word. The packet type is in data bits [3:0] of the first beat.

Top module: `bob_deint`

## Requirements
- R1: A packet of type 15 is a control packet with four beats: header, width, height, field flag (bit 0). It is forwarded with the same framing. Width passes unchanged, the height beat is doubled, and the field beat is sent as zero.
- R2: For a video packet (type 0), the header beat is forwarded. Each input pixel is accepted in the same cycle it is emitted. Each row is then emitted a second time with in_ready held low.
- R3: A complete video packet of width W and height H gives a header followed by 2H lines of W pixels. End-of-packet is set only on the last pixel. This holds under input and output stalls.
- R4: If input end-of-packet arrives after W*H pixels, the extra beats are consumed with no output. The next packet is then handled normally.
- R5: If input end-of-packet arrives before W*H pixels, the current line is completed with zero pixels and emitted twice. End-of-packet is set on the last pixel of the repeat. A cut exactly at a line end adds no padding.
- R6: When discard_en is high and the latest field flag is 1, the whole video packet is consumed with no output. With discard_en low, such a field is processed normally.
- R7: Width and height are taken from the most recent control packet, committed when its end-of-packet beat is accepted. A control packet that ends early keeps the earlier values for the fields it omitted.
- R8: Packets of any type other than 0 or 15 are forwarded unchanged.
- R9: Beats that arrive outside a packet (no start marker while idle) are consumed and produce no output.
- R10: After reset, out_valid is low while no input is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| discard_en | input | 1 | Drop video packets whose field flag is 1 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input beat data |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DW | Output beat data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |

## Verification
Two events can fall on the same input beat: the pixel count reaching the end of the field, and an input end-of-packet. When both land on the last pixel of the last row, the block must close the frame without padding and must not drain. A complete field is therefore sent with its final pixel marked as the end of the packet, and the next video packet follows with no gap while both sides stall. The judgement is that the two frames come out exactly as specified, with the second starting straight after the first.

// File: rtl/bob_deint.sv
module bob_deint #(
  parameter int DW    = 16,
  parameter int MAXW  = 64,
  parameter int HW    = 12,
  parameter int DEF_W = 4,
  parameter int DEF_H = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          discard_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop
);
  localparam int AW = $clog2(MAXW);
  localparam int WW = $clog2(MAXW + 1);
  localparam logic [3:0] T_VID = 4'h0;
  localparam logic [3:0] T_CTL = 4'hF;

  typedef enum logic [2:0] {IDLE, PASS, LINE_A, LINE_B, DRAIN} st_t;
  st_t st;

  logic [WW-1:0] wid, w_sh, w_nx;
  logic [HW-1:0] hgt, h_sh, h_nx;
  logic          fld, f_sh, f_nx;
  logic          ctl_q, ended;
  logic [1:0]    bcnt;
  logic [AW-1:0] col;
  logic [HW-1:0] row;
  logic [DW-1:0] lbuf [MAXW];

  wire [3:0] in_type  = in_data[3:0];
  wire drop_vid = discard_en && fld && in_type == T_VID;
  wire last_col = (WW'(col) == wid - 1'b1);
  wire last_row = (row == hgt - 1'b1);
  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  wire [WW-1:0] w_in = (in_data == '0) ? WW'(1) :
                       (in_data > DW'(MAXW)) ? WW'(MAXW) : in_data[WW-1:0];
  wire [HW-1:0] h_in = (in_data[HW-1:0] == '0) ? HW'(1) : in_data[HW-1:0];

  assign w_nx = (ctl_q && bcnt == 2'd1) ? w_in : w_sh;
  assign h_nx = (ctl_q && bcnt == 2'd2) ? h_in : h_sh;
  assign f_nx = (ctl_q && bcnt == 2'd3) ? in_data[0] : f_sh;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    case (st)
      IDLE:
        if (!in_sop || drop_vid) in_ready = 1'b1;
        else begin
          out_valid = in_valid;
          in_ready  = out_ready;
          out_sop   = 1'b1;
          out_eop   = in_eop;
        end
      PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_eop   = in_eop;
        if (ctl_q && bcnt == 2'd2) out_data = in_data << 1;
        if (ctl_q && bcnt == 2'd3) out_data = '0;
      end
      LINE_A:
        if (ended) begin
          out_valid = 1'b1;
          out_data  = '0;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      LINE_B: begin
        out_valid = 1'b1;
        out_data  = lbuf[col];
        out_eop   = last_col && (ended || last_row);
      end
      default: in_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk)
    if (st == LINE_A && out_fire) lbuf[col] <= out_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      wid   <= WW'(DEF_W);
      hgt   <= HW'(DEF_H);
      fld   <= 1'b0;
      w_sh  <= WW'(DEF_W);
      h_sh  <= HW'(DEF_H);
      f_sh  <= 1'b0;
      ctl_q <= 1'b0;
      ended <= 1'b0;
      bcnt  <= '0;
      col   <= '0;
      row   <= '0;
    end else begin
      case (st)
        IDLE:
          if (in_fire && in_sop && !in_eop) begin
            if (in_type != T_VID) begin
              st    <= PASS;
              ctl_q <= (in_type == T_CTL);
              bcnt  <= 2'd1;
              w_sh  <= wid;
              h_sh  <= hgt;
              f_sh  <= fld;
            end else if (drop_vid) st <= DRAIN;
            else begin
              st    <= LINE_A;
              col   <= '0;
              row   <= '0;
              ended <= 1'b0;
            end
          end
        PASS:
          if (in_fire) begin
            w_sh <= w_nx;
            h_sh <= h_nx;
            f_sh <= f_nx;
            if (bcnt != 2'd3) bcnt <= bcnt + 2'd1;
            if (in_eop) begin
              st <= IDLE;
              if (ctl_q) begin
                wid <= w_nx;
                hgt <= h_nx;
                fld <= f_nx;
              end
            end
          end
        LINE_A:
          if (out_fire) begin
            if (in_fire && in_eop) ended <= 1'b1;
            if (last_col) begin
              col <= '0;
              st  <= LINE_B;
            end else col <= col + 1'b1;
          end
        LINE_B:
          if (out_fire) begin
            if (last_col) begin
              col <= '0;
              if (ended) st <= IDLE;
              else if (last_row) st <= DRAIN;
              else begin
                row <= row + 1'b1;
                st  <= LINE_A;
              end
            end else col <= col + 1'b1;
          end
        default:
          if (in_fire && in_eop) st <= IDLE;
      endcase
    end
  end

  logic opkt;
  always_ff @(posedge clk)
    if (!rst_n) opkt <= 1'b0;
    else if (out_fire) opkt <= !out_eop;

  p_sop_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !opkt);
  p_body_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> opkt);
  p_col_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LINE_A || st == LINE_B) |-> WW'(col) < wid);
  p_replay_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == LINE_B |-> !in_ready);
  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == DRAIN |-> !out_valid);
  p_dims_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st != PASS |=> $stable(wid) && $stable(hgt));
endmodule

// File: tb/bob_deint_test.sv
module bob_deint_test;
  localparam int DW = 16;
  typedef logic [DW+1:0] beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic discard_en = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  bob_deint #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .discard_en(discard_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop));

  beat_t src_q[$], exp_q[$], got_q[$];
  int n_chk = 0, n_bad = 0;
  int both_c, oonly_c, ionly_c;
  logic [7:0] lfsr = 8'h5A;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(bit stall);
    int idle = 0;
    both_c = 0; oonly_c = 0; ionly_c = 0;
    while (idle < 40) begin
      bit fi, fo;
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (src_q.size() > 0) begin
        in_valid = stall ? (lfsr[1] | lfsr[4]) : 1'b1;
        {in_sop, in_eop, in_data} = src_q[0];
      end else in_valid = 1'b0;
      out_ready = stall ? (lfsr[2] | lfsr[6]) : 1'b1;
      #1;
      fi = in_valid && in_ready;
      fo = out_valid && out_ready;
      if (fi) void'(src_q.pop_front());
      if (fo) got_q.push_back({out_sop, out_eop, out_data});
      if (fi && fo) both_c++;
      else if (fo) oonly_c++;
      else if (fi) ionly_c++;
      idle = (fi || fo) ? 0 : idle + 1;
    end
    in_valid = 1'b0;
  endtask

  task automatic compare(string req);
    int bad = -1;
    chk(got_q.size() == exp_q.size(), req, "beat count", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    if (bad >= 0)
      chk(1'b0, req, $sformatf("beat %0d {sop,eop,data}", bad), got_q[bad], exp_q[bad]);
    else chk(1'b1, req, "beats", 0, 0);
    got_q.delete(); exp_q.delete(); src_q.delete();
  endtask

  task automatic src_ctrl(int w, int h, int f);
    src_q.push_back({2'b10, 16'h000F});
    src_q.push_back({2'b00, 16'(w)});
    src_q.push_back({2'b00, 16'(h)});
    src_q.push_back({2'b01, 16'(f)});
  endtask

  task automatic exp_ctrl(int w, int h);
    exp_q.push_back({2'b10, 16'h000F});
    exp_q.push_back({2'b00, 16'(w)});
    exp_q.push_back({2'b00, 16'(2 * h)});
    exp_q.push_back({2'b01, 16'h0000});
  endtask

  task automatic src_video(int base, int n);
    src_q.push_back({1'b1, 1'b0, 16'h0000});
    for (int i = 0; i < n; i++) src_q.push_back({1'b0, i == n - 1, 16'(base + i)});
  endtask

  task automatic exp_video(int base, int w, int h, int n);
    int lines = (n >= w * h) ? h : (n + w - 1) / w;
    exp_q.push_back({1'b1, 1'b0, 16'h0000});
    for (int r = 0; r < lines; r++)
      for (int k = 0; k < 2; k++)
        for (int c = 0; c < w; c++) begin
          int idx = r * w + c;
          exp_q.push_back({1'b0, (k == 1 && c == w - 1 && r == lines - 1),
                           (idx < n) ? 16'(base + idx) : 16'h0000});
        end
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_basic;
    src_ctrl(4, 2, 0); src_video(1, 8);
    exp_ctrl(4, 2); exp_video(1, 4, 2, 8);
    run(1'b0);
    chk(both_c == 13, "R2", "cycles accepting and emitting together", both_c, 13);
    chk(oonly_c == 8, "R2", "replay cycles without input", oonly_c, 8);
    compare("R1 R3");
  endtask

  task automatic t_stall;
    src_ctrl(5, 3, 0); src_video(100, 15);
    exp_ctrl(5, 3); exp_video(100, 5, 3, 15);
    run(1'b1);
    compare("R3");
  endtask

  task automatic t_late;
    src_ctrl(3, 2, 0); src_video(40, 9); src_video(60, 6);
    exp_ctrl(3, 2); exp_video(40, 3, 2, 9); exp_video(60, 3, 2, 6);
    run(1'b1);
    compare("R4");
  endtask

  task automatic t_early;
    src_ctrl(4, 3, 0); src_video(10, 6); src_video(30, 4);
    exp_ctrl(4, 3); exp_video(10, 4, 3, 6); exp_video(30, 4, 3, 4);
    run(1'b1);
    compare("R5");
  endtask

  task automatic t_exact;
    src_ctrl(4, 2, 0); src_video(1, 8); src_video(50, 8);
    exp_ctrl(4, 2); exp_video(1, 4, 2, 8); exp_video(50, 4, 2, 8);
    run(1'b1);
    compare("R3 R4 R5 exact end");
  endtask

  task automatic t_drop;
    discard_en = 1'b1;
    src_ctrl(4, 2, 1); src_video(5, 8);
    exp_ctrl(4, 2);
    run(1'b0);
    chk(oonly_c == 0, "R6", "output-only cycles while dropping", oonly_c, 0);
    chk(ionly_c == 9, "R6", "input beats consumed silently", ionly_c, 9);
    compare("R6 dropped");
    src_ctrl(4, 2, 0); src_video(5, 8);
    exp_ctrl(4, 2); exp_video(5, 4, 2, 8);
    run(1'b1);
    compare("R6 kept parity");
    discard_en = 1'b0;
    src_ctrl(4, 2, 1); src_video(7, 8);
    exp_ctrl(4, 2); exp_video(7, 4, 2, 8);
    run(1'b0);
    compare("R6 disabled");
  endtask

  task automatic t_dims;
    src_ctrl(2, 1, 0); src_video(1, 2); src_ctrl(6, 2, 0); src_video(20, 12);
    exp_ctrl(2, 1); exp_video(1, 2, 1, 2); exp_ctrl(6, 2); exp_video(20, 6, 2, 12);
    run(1'b1);
    compare("R7");
    src_q.push_back({2'b10, 16'h000F});
    src_q.push_back({2'b00, 16'd3});
    src_q.push_back({2'b01, 16'd2});
    src_video(70, 6);
    exp_q.push_back({2'b10, 16'h000F});
    exp_q.push_back({2'b00, 16'd3});
    exp_q.push_back({2'b01, 16'd4});
    exp_video(70, 3, 2, 6);
    run(1'b0);
    compare("R7 short control");
  endtask

  task automatic t_other;
    src_q.push_back({2'b10, 16'h0003});
    src_q.push_back({2'b00, 16'd7});
    src_q.push_back({2'b00, 16'd9});
    src_q.push_back({2'b01, 16'd11});
    foreach (src_q[i]) exp_q.push_back(src_q[i]);
    run(1'b1);
    compare("R8");
  endtask

  task automatic t_stray;
    src_q.push_back({2'b00, 16'd5});
    src_q.push_back({2'b01, 16'd6});
    src_ctrl(2, 2, 0); src_video(9, 4);
    exp_ctrl(2, 2); exp_video(9, 2, 2, 4);
    run(1'b0);
    compare("R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    t_reset;
    t_basic;
    t_stall;
    t_late;
    t_early;
    t_exact;
    t_drop;
    t_dims;
    t_other;
    t_stray;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule